// File: doc/BRIEF.md
# Fast Serial Port Register File

This block is the 32-bit register front end of a fixed-format serial port that always sends and receives 8 data bits, with no parity and one stop bit. It holds a receive FIFO and a transmit FIFO. Five word-aligned registers give access to the data path, the FIFO occupancy, a set of interrupt status bits, a control word and a bit-rate divisor. The serializer sits on the far side. It drains transmit bytes through a take strobe. It delivers each received byte together with its framing-error and break flags, and it signals a receive idle timeout.

The interrupt status bits come in two kinds. Some are latched events that software clears by writing ones. Others are live level conditions that follow FIFO occupancy against programmable thresholds. A single interrupt line combines the latched and level bits, gated by three enable groups. A read of the data register pops one receive entry and returns its byte, its flags and an empty indication in the same word.

Top module: `fast_uart_regs`

## Requirements
- R1: After reset the status register reads 0x40, the level, control and rate registers read 0, and irq and line_break are 0.
- R2: A write to offset 0x00 pushes wdata[7:0] into the transmit FIFO. The serializer receives those bytes on tx_byte in write order, one per tx_take pulse while tx_avail is 1.
- R3: Offset 0x04 reads the receive count in bits 7:0 and the transmit count in bits 15:8.
- R4: A read of offset 0x00 returns the oldest receive byte in bits 7:0, its framing flag in bit 9 and its break flag in bit 10, and removes that entry. If the receive FIFO is empty, the read returns 0x100 and removes nothing.
- R5: Status bit 3 latches when a received byte carries a framing error, and bit 4 latches when a received byte carries a break. Writing 1 to status bits 0, 3, 4 or 5 clears them. Writes to bits 1, 2 and 6 have no effect. If an event and a clear fall in the same cycle, the event wins.
- R6: irq is 1 when any of these holds: status bit 0 with control bit 5 set; status bit 1 or 2 with control bit 6 set; status bit 3, 4 or 5 with control bit 7 set.
- R7: Status bit 1 is 1 while the receive count is at or above the threshold chosen by control bits 4:2. The codes 0 to 5 select 1, 4, 8, 16, 32 and 48; codes 6 and 7 select 48.
- R8: A byte that arrives while the receive FIFO is full, with no pop in the same cycle, is dropped and sets status bit 5.
- R9: Status bit 6 is 1 while the transmit count is at or below the threshold chosen by control bits 1:0 (0, 4, 8 or 16). Status bit 0 latches each time bit 6 goes from 0 to 1.
- R10: The control register keeps bits 8:0 and reads 0 above them. Control bit 8 drives line_break.
- R11: The rate register keeps the low 8 bits written to offset 0x10 and drives them on rate_div.
- R12: A pulse on rx_idle sets status bit 2. A read of offset 0x00 that removes an entry clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit FIFO not empty |
| tx_take | input | 1 | Serializer takes tx_byte |
| rx_byte | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error on rx_byte |
| rx_brk | input | 1 | Break on rx_byte |
| rx_push | input | 1 | rx_byte is valid this cycle |
| rx_idle | input | 1 | Receive inactivity timeout event |
| line_break | output | 1 | Forces break on the line |
| rate_div | output | 8 | Bit-rate divisor |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default FIFO depth of 64 and an 8-bit rate field. At that depth the receive FIFO can be filled in a short run, so the bench can push a 65th byte to reach the overrun drop, and it can exercise a receive threshold that is not trivial. The transmit side is drained in metered steps so that the occupancy crosses the 4-byte threshold exactly, which exposes the edge-triggered latch of status bit 0.

// File: rtl/fast_uart_pkg.sv
package fast_uart_pkg;

  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_DATA  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_LEVEL = 5'h04;
  localparam logic [REG_AW-1:0] OFS_STAT  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_RATE  = 5'h10;

  localparam int unsigned ST_W      = 7;
  localparam int unsigned ST_TXREQ  = 0;
  localparam int unsigned ST_RXTRIG = 1;
  localparam int unsigned ST_RXTMO  = 2;
  localparam int unsigned ST_FERR   = 3;
  localparam int unsigned ST_BRK    = 4;
  localparam int unsigned ST_OVR    = 5;
  localparam int unsigned ST_TXLOW  = 6;

  localparam logic [ST_W-1:0] W1C_MASK = 7'b0111001;

  localparam int unsigned CTRL_W = 9;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic [7:0] data;
  } rx_entry_t;

  function automatic logic [7:0] rx_thresh(input logic [2:0] code);
    case (code)
      3'd0:    rx_thresh = 8'd1;
      3'd1:    rx_thresh = 8'd4;
      3'd2:    rx_thresh = 8'd8;
      3'd3:    rx_thresh = 8'd16;
      3'd4:    rx_thresh = 8'd32;
      default: rx_thresh = 8'd48;
    endcase
  endfunction

  function automatic logic [7:0] tx_thresh(input logic [1:0] code);
    case (code)
      2'd0:    tx_thresh = 8'd0;
      2'd1:    tx_thresh = 8'd4;
      2'd2:    tx_thresh = 8'd8;
      default: tx_thresh = 8'd16;
    endcase
  endfunction

endpackage

// File: rtl/fu_fifo.sv
module fu_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);
  assign rdata   = mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end
endmodule

// File: rtl/fu_irq_ctl.sv
module fu_irq_ctl
  import fast_uart_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_trig_lvl,
  input  logic            tx_low_lvl,
  input  logic            fe_ev,
  input  logic            brk_ev,
  input  logic            ovr_ev,
  input  logic            tmo_ev,
  input  logic            tmo_clr,
  input  logic [ST_W-1:0] w1c,
  input  logic            tx_en,
  input  logic            rx_en,
  input  logic            err_en,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic txreq_q, txreq_d;
  logic tmo_q, tmo_d;
  logic fe_q, fe_d;
  logic brk_q, brk_d;
  logic ovr_q, ovr_d;
  logic txlow_q;

  always_comb begin
    txreq_d = (txreq_q & ~w1c[ST_TXREQ]) | (tx_low_lvl & ~txlow_q);
    tmo_d   = (tmo_q & ~tmo_clr) | tmo_ev;
    fe_d    = (fe_q  & ~w1c[ST_FERR]) | fe_ev;
    brk_d   = (brk_q & ~w1c[ST_BRK])  | brk_ev;
    ovr_d   = (ovr_q & ~w1c[ST_OVR])  | ovr_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txreq_q <= 1'b0;
      tmo_q   <= 1'b0;
      fe_q    <= 1'b0;
      brk_q   <= 1'b0;
      ovr_q   <= 1'b0;
      txlow_q <= 1'b1;
    end else begin
      txreq_q <= txreq_d;
      tmo_q   <= tmo_d;
      fe_q    <= fe_d;
      brk_q   <= brk_d;
      ovr_q   <= ovr_d;
      txlow_q <= tx_low_lvl;
    end
  end

  always_comb begin
    status             = '0;
    status[ST_TXREQ]   = txreq_q;
    status[ST_RXTRIG]  = rx_trig_lvl;
    status[ST_RXTMO]   = tmo_q;
    status[ST_FERR]    = fe_q;
    status[ST_BRK]     = brk_q;
    status[ST_OVR]     = ovr_q;
    status[ST_TXLOW]   = tx_low_lvl;
  end

  assign irq = (tx_en  & txreq_q)
             | (rx_en  & (rx_trig_lvl | tmo_q))
             | (err_en & (fe_q | brk_q | ovr_q));
endmodule

// File: rtl/fast_uart_regs.sv
module fast_uart_regs
  import fast_uart_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned RATE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_byte,
  output logic              tx_avail,
  input  logic              tx_take,
  input  logic [7:0]        rx_byte,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              rx_push,
  input  logic              rx_idle,
  output logic              line_break,
  output logic [RATE_W-1:0] rate_div,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned RX_W  = $bits(rx_entry_t);

  logic wr_data, rd_data, wr_stat, wr_ctrl, wr_rate;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              unused_wdata;

  assign wr_data = bus_sel &  bus_wr & (bus_addr == OFS_DATA);
  assign rd_data = bus_sel & ~bus_wr & (bus_addr == OFS_DATA);
  assign wr_stat = bus_sel &  bus_wr & (bus_addr == OFS_STAT);
  assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == OFS_CTRL);
  assign wr_rate = bus_sel &  bus_wr & (bus_addr == OFS_RATE);
  assign unused_wdata = ^bus_wdata[31:CTRL_W];

  // transmit FIFO
  logic [CNT_W-1:0] tx_count;
  logic             tx_full, tx_empty;

  fu_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) tx_fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_data),
    .wdata (bus_wdata[7:0]),
    .pop   (tx_take),
    .rdata (tx_byte),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty)
  );
  assign tx_avail = ~tx_empty;

  // receive FIFO
  rx_entry_t        rx_in, rx_head;
  logic [RX_W-1:0]  rx_head_bits;
  logic [CNT_W-1:0] rx_count;
  logic             rx_full, rx_empty, rx_pop;

  assign rx_in  = '{brk: rx_brk, fe: rx_ferr, data: rx_byte};
  assign rx_pop = rd_data & ~rx_empty;

  fu_fifo #(.W(RX_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) rx_fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .wdata (rx_in),
    .pop   (rx_pop),
    .rdata (rx_head_bits),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty)
  );
  assign rx_head = rx_entry_t'(rx_head_bits);

  // control and rate registers
  always_comb begin
    ctrl_d = ctrl_q;
    rate_d = rate_q;
    if (wr_ctrl) ctrl_d = bus_wdata[CTRL_W-1:0];
    if (wr_rate) rate_d = bus_wdata[RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rate_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rate_q <= rate_d;
    end
  end

  assign line_break = ctrl_q[8];
  assign rate_div   = rate_q;

  // status and interrupt
  logic            rx_trig, tx_low;
  logic [ST_W-1:0] status;

  assign rx_trig = 8'(rx_count) >= rx_thresh(ctrl_q[4:2]);
  assign tx_low  = 8'(tx_count) <= tx_thresh(ctrl_q[1:0]);

  fu_irq_ctl irq_ctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_trig_lvl (rx_trig),
    .tx_low_lvl  (tx_low),
    .fe_ev       (rx_push & rx_ferr),
    .brk_ev      (rx_push & rx_brk),
    .ovr_ev      (rx_push & rx_full & ~rx_pop),
    .tmo_ev      (rx_idle),
    .tmo_clr     (rx_pop),
    .w1c         (wr_stat ? (bus_wdata[ST_W-1:0] & W1C_MASK) : '0),
    .tx_en       (ctrl_q[5]),
    .rx_en       (ctrl_q[6]),
    .err_en      (ctrl_q[7]),
    .status      (status),
    .irq         (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_DATA:  bus_rdata = rx_empty ? 32'h100
                             : {21'b0, rx_head.brk, rx_head.fe, 1'b0, rx_head.data};
        OFS_LEVEL: bus_rdata = {16'b0, 8'(tx_count), 8'(rx_count)};
        OFS_STAT:  bus_rdata = 32'(status);
        OFS_CTRL:  bus_rdata = 32'(ctrl_q);
        OFS_RATE:  bus_rdata = 32'(rate_q);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fast_uart_regs_chk.sv
module fast_uart_regs_chk
  import fast_uart_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned RATE_W     = 8,
  parameter int unsigned CNT_W      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rx_push,
  input logic              rx_ferr,
  input logic              rx_full,
  input logic              rx_pop,
  input logic [CNT_W-1:0]  rx_count,
  input logic [ST_W-1:0]   status,
  input logic              tx_low,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [RATE_W-1:0] rate_div,
  input logic              irq
);
  assert_fe_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_ferr |=> status[ST_FERR]);

  assert_overrun_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full && !rx_pop |=> status[ST_OVR] && $stable(rx_count));

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(FIFO_DEPTH));

  assert_txreq_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_low) |=> status[ST_TXREQ]);

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7:5] == 3'b000 |-> !irq);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && bus_addr == OFS_DATA && rx_count == '0 && !rx_push
    |=> rx_count == '0);

  assert_rate_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == OFS_RATE
    |=> rate_div == $past(bus_wdata[RATE_W-1:0]));
endmodule

bind fast_uart_regs fast_uart_regs_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .RATE_W     (RATE_W),
  .CNT_W      (CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rx_push   (rx_push),
  .rx_ferr   (rx_ferr),
  .rx_full   (rx_full),
  .rx_pop    (rx_pop),
  .rx_count  (rx_count),
  .status    (status),
  .tx_low    (tx_low),
  .ctrl_q    (ctrl_q),
  .rate_div  (rate_div),
  .irq       (irq)
);

// File: tb/fast_uart_regs_tb_top.sv
module fast_uart_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_byte;
  logic        tx_avail;
  logic        tx_take = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ferr = 1'b0, rx_brk = 1'b0, rx_push = 1'b0, rx_idle = 1'b0;
  logic        line_break;
  logic [7:0]  rate_div;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int drain_budget = 0;
  logic [7:0]  txq[$];
  logic [31:0] rxq[$];

  always #2 clk = ~clk;

  fast_uart_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_byte(tx_byte), .tx_avail(tx_avail), .tx_take(tx_take),
    .rx_byte(rx_byte), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_push(rx_push),
    .rx_idle(rx_idle), .line_break(line_break), .rate_div(rate_div), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr_t(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_rd_t(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    bus_rd_t(a, v);
    chk(v == exp, req, v, exp);
  endtask

  // driver: one received byte; expected word queued only if the byte is kept
  task automatic rx_send(input logic [7:0] b, input bit fe, input bit brk, input bit keep);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b; rx_ferr = fe; rx_brk = brk;
    if (keep) rxq.push_back({21'b0, brk, fe, 1'b0, b});
    @(negedge clk);
    rx_push = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  // scoreboard pop for the receive side
  task automatic rx_pop_chk(input string req);
    logic [31:0] v, e;
    bus_rd_t(5'h00, v);
    e = rxq.pop_front();
    chk(v == e, req, v, e);
  endtask

  task automatic tx_send(input logic [7:0] b);
    txq.push_back(b);
    bus_wr_t(5'h00, {24'h0, b});
  endtask

  task automatic wait_drained;
    while (drain_budget > 0 && txq.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: transmit scoreboard, metered by drain_budget
  initial begin
    forever begin
      @(negedge clk);
      tx_take = 1'b0;
      if (rst_n && drain_budget > 0 && tx_avail) begin
        if (txq.size() == 0) chk(1'b0, "R2", 32'(tx_byte), 32'hFFFF_FFFF);
        else begin
          logic [7:0] e;
          e = txq.pop_front();
          chk(tx_byte == e, "R2", 32'(tx_byte), 32'(e));
        end
        tx_take = 1'b1;
        drain_budget--;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd_chk(5'h08, 32'h40, "R1 status");
    rd_chk(5'h04, 32'h0,  "R1 level");
    rd_chk(5'h0C, 32'h0,  "R1 ctrl");
    rd_chk(5'h10, 32'h0,  "R1 rate");
    chk(irq == 1'b0 && line_break == 1'b0, "R1 irq/break", {30'b0, irq, line_break}, 32'h0);

    // R2, R3: transmit order and level
    tx_send(8'hA5); tx_send(8'h3C); tx_send(8'h7E);
    rd_chk(5'h04, 32'h0300, "R3 tx level");
    drain_budget = 3;
    wait_drained();
    rd_chk(5'h04, 32'h0, "R3 level drained");
    rd_chk(5'h08, 32'h41, "R9 txreq latched on empty");
    bus_wr_t(5'h08, 32'h01);
    rd_chk(5'h08, 32'h40, "R5 w1c bit0");

    // R4, R5, R6, R7: receive with flags
    rx_send(8'h11, 0, 0, 1);
    rx_send(8'h22, 1, 0, 1);
    rx_send(8'h33, 0, 1, 1);
    rd_chk(5'h04, 32'h3, "R3 rx level");
    rd_chk(5'h08, 32'h5A, "R5 fe/brk latched R7 trig");
    chk(irq == 1'b0, "R6 irq masked", 32'(irq), 32'h0);
    bus_wr_t(5'h0C, 32'h80);
    @(negedge clk);
    chk(irq == 1'b1, "R6 irq err", 32'(irq), 32'h1);
    rx_pop_chk("R4 pop0"); rx_pop_chk("R4 pop1"); rx_pop_chk("R4 pop2");
    rd_chk(5'h00, 32'h100, "R4 empty read");
    rd_chk(5'h04, 32'h0, "R4 empty read no pop");
    rd_chk(5'h08, 32'h58, "R7 trig clears");
    bus_wr_t(5'h08, 32'h46);
    rd_chk(5'h08, 32'h58, "R5 ignored bits");
    bus_wr_t(5'h08, 32'h18);
    rd_chk(5'h08, 32'h40, "R5 w1c fe/brk");
    chk(irq == 1'b0, "R6 irq cleared", 32'(irq), 32'h0);

    // R7: receive threshold of 8
    bus_wr_t(5'h0C, 32'h48);
    for (int i = 0; i < 7; i++) rx_send(8'(8'h40 + i), 0, 0, 1);
    rd_chk(5'h08, 32'h40, "R7 below trigger");
    chk(irq == 1'b0, "R6 rx irq low", 32'(irq), 32'h0);
    rx_send(8'h47, 0, 0, 1);
    rd_chk(5'h08, 32'h42, "R7 at trigger");
    chk(irq == 1'b1, "R6 rx irq high", 32'(irq), 32'h1);
    for (int i = 0; i < 8; i++) rx_pop_chk("R4 trig drain");

    // R8: overrun
    bus_wr_t(5'h0C, 32'h80);
    for (int i = 0; i < 64; i++) rx_send(8'(i * 3), 0, 0, 1);
    rd_chk(5'h04, 32'h40, "R8 full level");
    rd_chk(5'h08, 32'h42, "R8 no overrun yet");
    rx_send(8'hEE, 0, 0, 0);
    rd_chk(5'h04, 32'h40, "R8 level held");
    rd_chk(5'h08, 32'h62, "R8 overrun set");
    chk(irq == 1'b1, "R8 R6 overrun irq", 32'(irq), 32'h1);
    for (int i = 0; i < 64; i++) rx_pop_chk("R8 drop check");
    bus_wr_t(5'h08, 32'h20);
    rd_chk(5'h08, 32'h40, "R5 w1c overrun");

    // R12: idle timeout
    @(negedge clk); rx_idle = 1'b1;
    @(negedge clk); rx_idle = 1'b0;
    rd_chk(5'h08, 32'h44, "R12 timeout set");
    bus_wr_t(5'h0C, 32'h40);
    @(negedge clk);
    chk(irq == 1'b1, "R12 R6 timeout irq", 32'(irq), 32'h1);
    rx_send(8'h5A, 0, 0, 1);
    rx_pop_chk("R12 pop");
    rd_chk(5'h08, 32'h40, "R12 cleared by pop");
    chk(irq == 1'b0, "R12 irq low", 32'(irq), 32'h0);

    // R9: transmit threshold of 4
    bus_wr_t(5'h0C, 32'h01);
    for (int i = 0; i < 6; i++) tx_send(8'(8'hC0 + i));
    rd_chk(5'h08, 32'h00, "R9 above trigger");
    drain_budget = 2;
    wait_drained();
    rd_chk(5'h04, 32'h0400, "R3 tx level 4");
    rd_chk(5'h08, 32'h41, "R9 at trigger");
    bus_wr_t(5'h0C, 32'h21);
    @(negedge clk);
    chk(irq == 1'b1, "R9 R6 tx irq", 32'(irq), 32'h1);
    drain_budget = 4;
    wait_drained();
    rd_chk(5'h04, 32'h0, "R2 all drained");

    // R10, R11
    bus_wr_t(5'h0C, 32'hFFFF_FFFF);
    rd_chk(5'h0C, 32'h1FF, "R10 ctrl width");
    chk(line_break == 1'b1, "R10 break", 32'(line_break), 32'h1);
    bus_wr_t(5'h0C, 32'h0);
    chk(line_break == 1'b0, "R10 break off", 32'(line_break), 32'h0);
    bus_wr_t(5'h10, 32'h1234_56AB);
    rd_chk(5'h10, 32'hAB, "R11 rate");
    chk(rate_div == 8'hAB, "R11 rate out", 32'(rate_div), 32'hAB);

    finish_run();
  end
endmodule